// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock Register Block

This block keeps the time of day and the calendar date in packed BCD: seconds, minutes, hours, day of month, month and a two-digit year, plus a day-of-week counter. A single-cycle pulse on the one-hertz tick input advances the clock by one second. The pulse comes from an external prescaler. The carry ripples through the fields, and the day field uses month lengths that account for leap years.

Software reaches the block through a byte-wide register port. Writes take effect on the clock edge and reads are combinational from the address. Through this port software sets the time and an alarm, starts and stops counting, and takes a coherent snapshot of the counters for multi-byte reads. It also reads sticky event flags and clears them by writing 1, and selects which events drive the single interrupt line. The interrupt combines an alarm match with a periodic event. The period can be one second, one minute, one hour or one day.

Top module: `bcd_rtc_regs`

## Requirements
- R1: After reset the time reads 00:00:00, the day and month read 0x01, the year and week read 0x00, control reads 0x00 (stopped), the interrupt enable reads 0x00, status reads 0x80 and the interrupt output is low.
- R2: Offsets 0x00..0x05 are seconds, minutes, hours, day, month and year, 0x06 is the day of week (0..6), 0x07..0x0C are the alarm fields in the same field order, 0x0D is control, 0x0E is status and 0x0F is interrupt enable.
- R3: While control bit 0 (run) is 1, each tick adds one second in BCD, so 0x09 becomes 0x10. While run is 0, ticks change nothing.
- R4: Writes to offsets 0x00..0x06 load the field only while run is 0 and are ignored while run is 1. Alarm fields are writable at any time.
- R5: Seconds wrap 0x59 to 0x00 with a carry into minutes, minutes wrap 0x59 to 0x00 into hours, and hours wrap 0x23 to 0x00 into the day and the day of week. The day of week wraps 6 to 0, month 0x12 wraps to 0x01 with a carry into the year, and year 0x99 wraps to 0x00.
- R6: The day wraps to 0x01 after the last day of the month. April, June, September and November have 30 days, February has 29 days in years divisible by 4 (including 00) and 28 days otherwise, and all other months have 31.
- R7: A control write with bit 6 set captures the counters as they were before that edge. While control bit 6 reads 1, offsets 0x00..0x05 return the captured copy, and a control write with bit 6 clear returns the live values. Control reads back {0, bit6, 00000, run}.
- R8: Status bit 1 mirrors run. Bits 2, 3, 4 and 5 set on a counted tick, a minute boundary, an hour boundary and a day boundary. Bit 6 is the alarm flag and bit 7 is the power-up flag. Bit 0 reads 0.
- R9: Writing 1 to a status bit in 2..7 clears it, and writing 0 leaves it unchanged. Writing back a value just read clears every flag it showed. An event in the same cycle as its clear leaves the flag set, and only reset sets the power-up flag.
- R10: The alarm flag sets on the counted tick after which all six time fields equal the six alarm fields.
- R11: Interrupt enable bits [1:0] select the periodic event (00 second, 01 minute, 10 hour, 11 day), bit 2 enables the periodic interrupt and bit 3 enables the alarm interrupt. The interrupt output is (alarm flag AND bit 3) OR (selected event flag AND bit 2) and stays high until that flag is cleared.
- R12: A tick in the same cycle as a control write is counted according to the run value held before that write.
- R13: Addresses above 0x0F read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second from the prescaler |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W (5) | Register byte address |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt for alarm and periodic events |

## Verification
Several pairs of functions can land on the same clock edge: a counted tick and a control write that changes the run bit, a tick and a snapshot request, and a tick and a write-one-to-clear of the flag that tick sets. The bench provokes each pair by raising the tick and the write strobe together for one cycle. It then reads back the outcome. The seconds field must show the count that matches the old run value. The snapshot must show the pre-tick seconds while the live seconds move on. The event flag must stay set despite the clear.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

   localparam int FIELD_W  = 8;
   localparam int NUM_TIME = 6;

   // field offsets; behaviour depends on these for the burst order
   localparam logic [3:0] OFF_SEC   = 4'h0;
   localparam logic [3:0] OFF_WEEK  = 4'h6;
   localparam logic [3:0] OFF_ALM0  = 4'h7;
   localparam logic [3:0] OFF_CTRL  = 4'hD;
   localparam logic [3:0] OFF_STAT  = 4'hE;
   localparam logic [3:0] OFF_IEN   = 4'hF;

   // seconds is the least significant byte, so field i sits at [8*i +: 8]
   typedef struct packed {
      logic [7:0] yr;
      logic [7:0] mon;
      logic [7:0] day;
      logic [7:0] hr;
      logic [7:0] min;
      logic [7:0] sec;
   } rtc_time_t;

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      logic [7:0] r;
      if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
      logic [6:0] tens;
      logic [6:0] ones;
      tens = {3'b000, v[7:4]};
      ones = {3'b000, v[3:0]};
      return tens * 7'd10 + ones;
   endfunction

   function automatic logic [6:0] month_len(input logic [7:0] mon_bcd,
                                            input logic [7:0] yr_bcd);
      logic [6:0] yb;
      logic       leap;
      logic [6:0] n;
      yb   = bcd_to_bin(yr_bcd);
      leap = (yb[1:0] == 2'b00);
      case (mon_bcd)
         8'h02:                      n = leap ? 7'd29 : 7'd28;
         8'h04, 8'h06, 8'h09, 8'h11: n = 7'd30;
         default:                    n = 7'd31;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
   import rtc_pkg::*;
#(
   parameter int WEEK_DAYS = 7,
   localparam int WK_W     = $clog2(WEEK_DAYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adv,
   input  logic [NUM_TIME-1:0] ld_en,
   input  logic                wk_ld,
   input  logic [FIELD_W-1:0]  ld_data,
   output rtc_time_t           now_t,
   output rtc_time_t           nxt_t,
   output logic [WK_W-1:0]     week,
   output logic [3:0]          ev
);

   localparam rtc_time_t T_RST = '{yr: 8'h00, mon: 8'h01, day: 8'h01,
                                   hr: 8'h00, min: 8'h00, sec: 8'h00};

   rtc_time_t       t_q;
   logic [WK_W-1:0] wk_q;
   logic sec_w, min_w, hr_w, day_w, mon_w;

   always_comb begin
      sec_w = (t_q.sec == 8'h59);
      min_w = sec_w && (t_q.min == 8'h59);
      hr_w  = min_w && (t_q.hr == 8'h23);
      day_w = hr_w && (bcd_to_bin(t_q.day) == month_len(t_q.mon, t_q.yr));
      mon_w = day_w && (t_q.mon == 8'h12);

      nxt_t     = t_q;
      nxt_t.sec = sec_w ? 8'h00 : bcd_inc(t_q.sec);
      if (sec_w) nxt_t.min = min_w ? 8'h00 : bcd_inc(t_q.min);
      if (min_w) nxt_t.hr  = hr_w  ? 8'h00 : bcd_inc(t_q.hr);
      if (hr_w)  nxt_t.day = day_w ? 8'h01 : bcd_inc(t_q.day);
      if (day_w) nxt_t.mon = mon_w ? 8'h01 : bcd_inc(t_q.mon);
      if (mon_w) nxt_t.yr  = (t_q.yr == 8'h99) ? 8'h00 : bcd_inc(t_q.yr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_q <= T_RST;
      end else if (adv) begin
         t_q <= nxt_t;
      end else begin
         for (int i = 0; i < NUM_TIME; i++)
            if (ld_en[i]) t_q[FIELD_W*i +: FIELD_W] <= ld_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wk_q <= '0;
      else if (adv && hr_w)
         wk_q <= (wk_q == WK_W'(WEEK_DAYS - 1)) ? '0 : wk_q + WK_W'(1);
      else if (wk_ld)
         wk_q <= ld_data[WK_W-1:0];
   end

   assign now_t = t_q;
   assign week  = wk_q;
   // [0] second, [1] minute, [2] hour, [3] day boundary
   assign ev    = {adv & hr_w, adv & min_w, adv & sec_w, adv};

endmodule

// File: rtl/rtc_alarm_unit.sv
`timescale 1ns/1ps
module rtc_alarm_unit
   import rtc_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_TIME-1:0] ld_en,
   input  logic [FIELD_W-1:0]  ld_data,
   input  logic                adv,
   input  rtc_time_t           nxt_t,
   output rtc_time_t           alm_t,
   output logic                hit
);

   rtc_time_t a_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
      end else begin
         for (int i = 0; i < NUM_TIME; i++)
            if (ld_en[i]) a_q[FIELD_W*i +: FIELD_W] <= ld_data;
      end
   end

   // compared against the time the counted tick is about to produce
   assign hit   = adv && (nxt_t == a_q);
   assign alm_t = a_q;

endmodule

// File: rtl/rtc_event_status.sv
`timescale 1ns/1ps
module rtc_event_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] ev,
   input  logic       alarm_hit,
   input  logic       clr_we,
   input  logic [5:0] clr_mask,   // status bits 7..2
   input  logic       run,
   input  logic [3:0] ien,
   output logic [7:0] stat,
   output logic       irq
);

   logic [3:0] ev_q;
   logic       alm_q;
   logic       pu_q;
   logic [5:0] clr;

   assign clr = clr_we ? clr_mask : 6'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q  <= '0;
         alm_q <= 1'b0;
         pu_q  <= 1'b1;
      end else begin
         ev_q  <= (ev_q & ~clr[3:0]) | ev;
         alm_q <= (alm_q & ~clr[4]) | alarm_hit;
         pu_q  <= pu_q & ~clr[5];
      end
   end

   assign stat = {pu_q, alm_q, ev_q, run, 1'b0};
   assign irq  = (alm_q & ien[3]) | (ev_q[ien[1:0]] & ien[2]);

endmodule

// File: rtl/bcd_rtc_regs.sv
`timescale 1ns/1ps
module bcd_rtc_regs
   import rtc_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 8,
   parameter int WEEK_DAYS   = 7,
   parameter bit SNAPSHOT_EN = 1'b1,
   localparam int WK_W       = $clog2(WEEK_DAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   generate
      if (DATA_W != FIELD_W) begin : g_bad_data_w
         $error("bcd_rtc_regs: DATA_W must equal the BCD field width");
      end
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("bcd_rtc_regs: ADDR_W must cover 16 registers");
      end
      if (WEEK_DAYS < 2 || WEEK_DAYS > 8) begin : g_bad_week
         $error("bcd_rtc_regs: WEEK_DAYS out of range");
      end
   endgenerate

   logic       in_range;
   logic [3:0] off;
   logic       sel;

   generate
      if (ADDR_W > 4) begin : g_hi_dec
         assign in_range = (bus_addr[ADDR_W-1:4] == '0);
      end else begin : g_no_hi
         assign in_range = 1'b1;
      end
   endgenerate

   assign off = bus_addr[3:0];
   assign sel = bus_we && in_range;

   logic run_q;
   logic snap_view_q;
   logic [3:0] ien_q;
   logic adv;

   logic [NUM_TIME-1:0] time_ld;
   logic [NUM_TIME-1:0] alm_ld;
   logic wk_ld, ctrl_we, stat_we, ien_we;

   always_comb begin
      for (int i = 0; i < NUM_TIME; i++) begin
         time_ld[i] = sel && !run_q && (off == OFF_SEC + 4'(i));
         alm_ld[i]  = sel && (off == OFF_ALM0 + 4'(i));
      end
   end

   assign wk_ld   = sel && !run_q && (off == OFF_WEEK);
   assign ctrl_we = sel && (off == OFF_CTRL);
   assign stat_we = sel && (off == OFF_STAT);
   assign ien_we  = sel && (off == OFF_IEN);

   // run value held before this edge decides whether the tick counts
   assign adv = tick_1hz && run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q       <= 1'b0;
         snap_view_q <= 1'b0;
         ien_q       <= '0;
      end else begin
         if (ctrl_we) begin
            run_q       <= bus_wdata[0];
            snap_view_q <= bus_wdata[6];
         end
         if (ien_we) ien_q <= bus_wdata[3:0];
      end
   end

   rtc_time_t       now_t;
   rtc_time_t       nxt_t;
   rtc_time_t       alm_t;
   rtc_time_t       view_t;
   logic [WK_W-1:0] week;
   logic [3:0]      ev;
   logic            alarm_hit;
   logic [7:0]      stat;

   rtc_calendar #(.WEEK_DAYS(WEEK_DAYS)) u_cal (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .ld_en   (time_ld),
      .wk_ld   (wk_ld),
      .ld_data (bus_wdata),
      .now_t   (now_t),
      .nxt_t   (nxt_t),
      .week    (week),
      .ev      (ev)
   );

   rtc_alarm_unit u_alm (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (alm_ld),
      .ld_data (bus_wdata),
      .adv     (adv),
      .nxt_t   (nxt_t),
      .alm_t   (alm_t),
      .hit     (alarm_hit)
   );

   rtc_event_status u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .alarm_hit (alarm_hit),
      .clr_we    (stat_we),
      .clr_mask  (bus_wdata[7:2]),
      .run       (run_q),
      .ien       (ien_q),
      .stat      (stat),
      .irq       (irq)
   );

   generate
      if (SNAPSHOT_EN) begin : g_snap
         rtc_time_t shadow_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               shadow_q <= '0;
            else if (ctrl_we && bus_wdata[6])
               shadow_q <= now_t;
         end
         assign view_t = snap_view_q ? shadow_q : now_t;
      end else begin : g_live
         assign view_t = now_t;
      end
   endgenerate

   logic [7:0] rd;
   always_comb begin
      case (off)
         4'h0:    rd = view_t.sec;
         4'h1:    rd = view_t.min;
         4'h2:    rd = view_t.hr;
         4'h3:    rd = view_t.day;
         4'h4:    rd = view_t.mon;
         4'h5:    rd = view_t.yr;
         4'h6:    rd = 8'(week);
         4'h7:    rd = alm_t.sec;
         4'h8:    rd = alm_t.min;
         4'h9:    rd = alm_t.hr;
         4'hA:    rd = alm_t.day;
         4'hB:    rd = alm_t.mon;
         4'hC:    rd = alm_t.yr;
         4'hD:    rd = {1'b0, snap_view_q, 5'b00000, run_q};
         4'hE:    rd = stat;
         default: rd = {4'b0000, ien_q};
      endcase
      bus_rdata = in_range ? rd : '0;
   end

endmodule

// File: rtl/rtc_regs_chk.sv
`timescale 1ns/1ps
module rtc_regs_chk #(
   parameter int ADDR_W      = 5,
   parameter bit SNAPSHOT_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_1hz,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              irq,
   input logic              run_q,
   input logic              snap_view_q,
   input logic [3:0]        ien_q,
   input logic [7:0]        stat,
   input logic [47:0]       now_t,
   input logic [47:0]       alm_t,
   input logic [47:0]       view_t
);

   // R3
   hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !bus_we) |=> $stable(now_t));

   // R4
   running_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !tick_1hz && bus_we && bus_addr < ADDR_W'(7)) |=> $stable(now_t));

   // R5
   second_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && run_q && now_t[7:0] == 8'h59) |=> (now_t[7:0] == 8'h00));

   // R9
   powerup_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat[7] |=> !stat[7]);

   // R11
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien_q[2] || ien_q[3]));

   // R10
   alarm_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(stat[6]) && !$past(bus_we)) |-> (now_t == alm_t));

   // R7
   snapshot_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SNAPSHOT_EN && snap_view_q && !(bus_we && bus_addr == ADDR_W'(13)))
      |=> $stable(view_t));

endmodule

bind bcd_rtc_regs rtc_regs_chk #(.ADDR_W(ADDR_W), .SNAPSHOT_EN(SNAPSHOT_EN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_1hz    (tick_1hz),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .irq         (irq),
   .run_q       (run_q),
   .snap_view_q (snap_view_q),
   .ien_q       (ien_q),
   .stat        (stat),
   .now_t       (now_t),
   .alm_t       (alm_t),
   .view_t      (view_t)
);

// File: tb/tb_bcd_rtc_regs.sv
`timescale 1ns/1ps
module tb_bcd_rtc_regs;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       bus_we = 1'b0;
   logic [4:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq;

   int nvec = 0;
   int nbad = 0;
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   bcd_rtc_regs dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_1hz  (tick_1hz),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      nvec++;
      if (got !== exp) begin
         nbad++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic rd_chk(input logic [4:0] a, input logic [7:0] exp, input string tag);
      logic [7:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic irq_chk(input logic exp, input string tag);
      #1;
      chk(tag, {7'b0, irq}, {7'b0, exp});
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
      tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
   endtask

   task automatic wr_tick(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_1hz = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; tick_1hz = 1'b0;
   endtask

   task automatic load_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
      wr(5'h0D, 8'h00);
      wr(5'h00, s); wr(5'h01, m); wr(5'h02, h);
      wr(5'h03, d); wr(5'h04, mo); wr(5'h05, y);
   endtask

   task automatic t_reset();
      rd_chk(5'h0E, 8'h80, "R1 status after reset");
      rd_chk(5'h0D, 8'h00, "R1 control after reset");
      rd_chk(5'h0F, 8'h00, "R1 int enable after reset");
      rd_chk(5'h00, 8'h00, "R1 seconds after reset");
      rd_chk(5'h03, 8'h01, "R1 day after reset");
      rd_chk(5'h04, 8'h01, "R1 month after reset");
      rd_chk(5'h05, 8'h00, "R1 year after reset");
      rd_chk(5'h06, 8'h00, "R1 week after reset");
      irq_chk(1'b0, "R1 irq after reset");
   endtask

   task automatic t_load_run();
      load_time(8'h09, 8'h34, 8'h05, 8'h15, 8'h07, 8'h42);
      rd_chk(5'h01, 8'h34, "R2 minutes offset");
      rd_chk(5'h05, 8'h42, "R2 year offset");
      tick();
      rd_chk(5'h00, 8'h09, "R3 stopped tick ignored");
      wr(5'h0D, 8'h01);
      tick();
      rd_chk(5'h00, 8'h10, "R3 BCD digit carry");
      rd_chk(5'h01, 8'h34, "R3 minutes untouched");
   endtask

   task automatic t_w1c();
      logic [7:0] v;
      rd_chk(5'h0E, 8'h86, "R8 status after counted tick");
      wr(5'h0E, 8'h04);
      rd_chk(5'h0E, 8'h82, "R9 clear second flag only");
      rd(5'h0E, v);
      wr(5'h0E, v);
      rd_chk(5'h0E, 8'h02, "R9 write back clears power-up");
      wr_tick(5'h0E, 8'h04);
      rd_chk(5'h0E, 8'h06, "R9 set beats clear");
   endtask

   task automatic t_carry();
      load_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
      wr(5'h06, 8'h06);
      wr(5'h0E, 8'hFF);
      wr(5'h0D, 8'h01);
      tick();
      rd_chk(5'h00, 8'h00, "R5 seconds wrap");
      rd_chk(5'h01, 8'h00, "R5 minutes wrap");
      rd_chk(5'h02, 8'h00, "R5 hours wrap");
      rd_chk(5'h03, 8'h01, "R5 day wrap");
      rd_chk(5'h04, 8'h01, "R5 month wrap");
      rd_chk(5'h05, 8'h00, "R5 year 99 wraps");
      rd_chk(5'h06, 8'h00, "R5 week wraps");
      rd_chk(5'h0E, 8'h3E, "R8 all boundary flags");
      load_time(8'h59, 8'h10, 8'h03, 8'h02, 8'h03, 8'h10);
      wr(5'h0D, 8'h01);
      tick();
      rd_chk(5'h01, 8'h11, "R5 minute carry only");
      rd_chk(5'h02, 8'h03, "R5 hour held");
   endtask

   task automatic roll(input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y,
                       input logic [7:0] ed, input logic [7:0] emo, input string tag);
      load_time(8'h59, 8'h59, 8'h23, d, mo, y);
      wr(5'h0D, 8'h01);
      tick();
      rd_chk(5'h03, ed, tag);
      rd_chk(5'h04, emo, tag);
   endtask

   task automatic t_leap();
      roll(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, "R6 leap Feb 28");
      roll(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, "R6 leap Feb 29");
      roll(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, "R6 common Feb 28");
      roll(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, "R6 year 00 leap");
      roll(8'h30, 8'h04, 8'h55, 8'h01, 8'h05, "R6 30-day month");
      roll(8'h30, 8'h01, 8'h55, 8'h31, 8'h01, "R6 31-day month");
   endtask

   task automatic t_running_write();
      logic [7:0] v;
      rd(5'h00, v);
      wr(5'h00, 8'h33);
      rd_chk(5'h00, v, "R4 running time write ignored");
      rd(5'h06, v);
      wr(5'h06, v ^ 8'h01);
      rd_chk(5'h06, v, "R4 running week write ignored");
      wr(5'h07, 8'h45);
      rd_chk(5'h07, 8'h45, "R4 alarm write while running");
   endtask

   task automatic t_snapshot();
      load_time(8'h03, 8'h02, 8'h01, 8'h10, 8'h10, 8'h10);
      wr(5'h0D, 8'h41);
      rd_chk(5'h0D, 8'h41, "R7 control readback");
      tick(); tick(); tick();
      rd_chk(5'h00, 8'h03, "R7 frozen copy");
      wr(5'h0D, 8'h01);
      rd_chk(5'h00, 8'h06, "R7 live after release");
      wr_tick(5'h0D, 8'h41);
      rd_chk(5'h00, 8'h06, "R7 capture is pre-tick");
      wr(5'h0D, 8'h01);
      rd_chk(5'h00, 8'h07, "R7 live moved on");
   endtask

   task automatic t_alarm();
      logic [7:0] v;
      load_time(8'h00, 8'h00, 8'h10, 8'h05, 8'h06, 8'h30);
      wr(5'h07, 8'h02); wr(5'h08, 8'h00); wr(5'h09, 8'h10);
      wr(5'h0A, 8'h05); wr(5'h0B, 8'h06); wr(5'h0C, 8'h30);
      wr(5'h0F, 8'h08);
      wr(5'h0E, 8'hFF);
      wr(5'h0D, 8'h01);
      tick();
      rd_chk(5'h0E, 8'h06, "R10 no match yet");
      irq_chk(1'b0, "R11 irq low before match");
      tick();
      rd_chk(5'h0E, 8'h46, "R10 alarm flag on match");
      irq_chk(1'b1, "R11 alarm irq");
      rd(5'h0E, v);
      wr(5'h0E, v);
      rd_chk(5'h0E, 8'h02, "R9 write back clears alarm");
      irq_chk(1'b0, "R11 irq drops on clear");
      wr(5'h0F, 8'h00);
      wr(5'h07, 8'h03);
      tick();
      rd_chk(5'h0E, 8'h46, "R10 flag with alarm irq off");
      irq_chk(1'b0, "R11 alarm masked");
      wr(5'h0E, 8'hFF);
   endtask

   task automatic t_periodic();
      wr(5'h0F, 8'h04);
      irq_chk(1'b0, "R11 periodic idle");
      tick();
      irq_chk(1'b1, "R11 per-second irq");
      wr(5'h0E, 8'h04);
      irq_chk(1'b0, "R11 per-second cleared");
      wr(5'h0F, 8'h05);
      tick();
      irq_chk(1'b0, "R11 minute select ignores second");
      wr(5'h0D, 8'h00);
      wr(5'h00, 8'h59);
      wr(5'h0D, 8'h01);
      tick();
      irq_chk(1'b1, "R11 per-minute irq");
      rd_chk(5'h00, 8'h00, "R11 at minute boundary");
      wr(5'h0F, 8'h00);
      wr(5'h0E, 8'hFF);
   endtask

   task automatic t_race();
      wr_tick(5'h0D, 8'h00);
      rd_chk(5'h00, 8'h01, "R12 stop write counts tick");
      rd_chk(5'h0D, 8'h00, "R12 stopped after write");
      wr_tick(5'h0D, 8'h01);
      rd_chk(5'h00, 8'h01, "R12 start write skips tick");
      tick();
      rd_chk(5'h00, 8'h02, "R12 counts after start");
   endtask

   task automatic t_range();
      logic [7:0] v;
      wr(5'h0D, 8'h00);
      rd(5'h00, v);
      wr(5'h10, 8'h77);
      rd_chk(5'h00, v, "R13 high write no alias");
      rd_chk(5'h10, 8'h00, "R13 high read zero");
      rd_chk(5'h1E, 8'h00, "R13 high status alias zero");
   endtask

   initial begin
      #3000000;
      if (!done) begin
         nbad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_run();
      t_w1c();
      t_carry();
      t_leap();
      t_running_write();
      t_snapshot();
      t_alarm();
      t_periodic();
      t_race();
      t_range();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule